// File: doc/BRIEF.md
# Discriminator Row Serializer

This block takes one latched row of discriminator results and shifts it off chip on a set of parallel serial pads. It also forwards a data clock at half the core clock rate and drives a frame marker for the acquisition system. The row sequencer pulses `row_load` once per row period. A row period is 16 core clock cycles, which is 8 serial bit times of 2 cycles each, so every pad carries its 8-bit slice of the row within one row period.

Each discriminator bit can be forced to zero by a disable mask. A test pattern can replace the row in two cases: on the extra lines appended after the pixel array when the extended frame mode is on, and on every line in transfer-test mode. In both cases the marker timing does not change.

Two synchronisation schemes are available to the acquisition side:
- **Marker mode.** The data clock runs continuously. When a request is present, the marker flags the final line of each frame.
- **Gated-clock mode.** The data clock is held low until a request meets the load of a frame's first line. It then runs until the request is found withdrawn at a later first-line load.

Top module: `disc_row_serializer`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the edge leaves `sdata`, `marker` and `dclk_out` all at 0.
- R2: Lane k carries word bits 8k+7 down to 8k, most significant first. The first bit appears in the cycle after the `row_load` edge. Each bit is held for 2 clock cycles.
- R3: A discriminator bit whose `disc_mask` bit is 1 is sent as 0. Unmasked bits pass unchanged.
- R4: Pattern bits are never affected by `disc_mask`.
- R5: A frame has ARRAY_LINES lines when `op_ext` is 0. It has ARRAY_LINES+TEST_LINES lines when `op_ext` is 1. Line indices count from 0, starting with the first load after reset. Lines with index at or above ARRAY_LINES carry `test_pattern`.
- R6: With `xfer_test` at 1, every line carries `test_pattern`, and the marker behaves exactly as in normal operation.
- R7: `marker` is 1 for the 8 bit times (16 cycles) of a frame's last line, provided `sync_req` was 1 at that line's load. Otherwise `marker` is 0.
- R8: With `sync_sel` = 0 (marker mode), `dclk_out` is low in the first cycle of each bit and high in the second. It keeps toggling even when no row is loaded.
- R9: With `sync_sel` = 1 (gated-clock mode), `dclk_out` stays low until a first-line load sees `sync_req` = 1. From that load it runs. It stops only at a later first-line load that sees `sync_req` = 0.
- R10: When 8 bits have been shifted and no new load arrives, `sdata` returns to all zeros and `marker` drops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| row_load | input | 1 | One-cycle pulse: latch a new row |
| row_data | input | ROW_BITS | Latched discriminator outputs |
| disc_mask | input | ROW_BITS | Per-discriminator disable, 1 = forced to 0 |
| test_pattern | input | ROW_BITS | Substitute word for test lines |
| op_ext | input | 1 | 1 = append TEST_LINES pattern lines to each frame |
| xfer_test | input | 1 | 1 = send the pattern on every line |
| sync_sel | input | 1 | 0 = marker mode, 1 = gated-clock mode |
| sync_req | input | 1 | Synchronisation request from acquisition |
| sdata | output | LANES | Serial data, one bit per pad |
| marker | output | 1 | Last-line-of-frame flag |
| dclk_out | output | 1 | Forwarded half-rate data clock |

## Verification
The `row_load` edge loads the shift registers and resets the bit phase, so bit j of a row is due in cycles 2j+1 and 2j+2 after the load is driven. `dclk_out` is high only in the second of those cycles. The marker follows the same 16-cycle window as the data, and a change to the gated clock enable shows in the second cycle after a first-line load. The bench drives and samples on falling edges and compares every one of the 16 cycles of each line against a value computed from the line index it tracks. Idle and free-running clock checks sample the cycles after the last shift.

// File: rtl/dser_pkg.sv
// Package: shared types and default sizes for the discriminator row serializer.
// Assumes: consumers import it; nothing here holds state.
package dser_pkg;

    // Synchronisation scheme chosen by the acquisition side
    typedef enum logic {
        SYNC_MARKER = 1'b0,
        SYNC_GATED  = 1'b1
    } sync_mode_e;

    localparam int DEF_ROW_BITS    = 128;
    localparam int DEF_LANES       = 16;
    localparam int DEF_ARRAY_LINES = 576;
    localparam int DEF_TEST_LINES  = 2;

endpackage

// File: rtl/dser_word_sel.sv
// Module: picks the word loaded into the lanes.
// It is either the masked discriminator row or the unmasked test pattern.
// Assumes: use_pat is valid in the cycle row_load is high.
module dser_word_sel #(
    parameter int ROW_BITS = 128
) (
    input  logic [ROW_BITS-1:0] disc,
    input  logic [ROW_BITS-1:0] mask,
    input  logic [ROW_BITS-1:0] pattern,
    input  logic                use_pat,
    output logic [ROW_BITS-1:0] word
);

    logic [ROW_BITS-1:0] masked;

    // Clear every disabled discriminator
    always_comb masked = disc & ~mask;

    // The pattern bypasses the mask
    always_comb word = use_pat ? pattern : masked;

endmodule

// File: rtl/dser_lane.sv
// Module: one serial pad.
// A LANE_BITS shift register, loaded in parallel and emptied MSB first.
// Assumes: load has priority over shift; zeros fill in from the bottom.
module dser_lane #(
    parameter int LANE_BITS = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 load,
    input  logic                 shift,
    input  logic [LANE_BITS-1:0] din,
    output logic                 sout
);

    logic [LANE_BITS-1:0] sr_q;

    // Parallel load, or advance by one bit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sr_q <= '0;
        end else if (load) begin
            sr_q <= din;
        end else if (shift) begin
            sr_q <= {sr_q[LANE_BITS-2:0], 1'b0};
        end
    end

    // The pad always shows the top bit
    always_comb sout = sr_q[LANE_BITS-1];

endmodule

// File: rtl/dser_frame_ctl.sv
// Module: frame and timing control.
// It holds the bit phase, the bit count inside a line, the line index inside
// a frame, the marker, and the gate of the forwarded clock.
// Assumes: row_load is a single-cycle pulse, at most once per 2*LANE_BITS cycles.
module dser_frame_ctl
    import dser_pkg::*;
#(
    parameter int ARRAY_LINES = 576,
    parameter int TEST_LINES  = 2,
    parameter int LANE_BITS   = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic row_load,
    input  logic op_ext,
    input  logic xfer_test,
    input  logic sync_sel,
    input  logic sync_req,
    output logic use_pat,
    output logic shift_en,
    output logic marker,
    output logic dclk_out
);

    localparam int FRAME_MAX = ARRAY_LINES + TEST_LINES;
    localparam int IDX_W     = (FRAME_MAX > 1) ? $clog2(FRAME_MAX) : 1;
    localparam int BCNT_W    = (LANE_BITS > 1) ? $clog2(LANE_BITS) : 1;

    sync_mode_e         mode;
    logic [IDX_W-1:0]   next_idx_q;
    logic [IDX_W-1:0]   last_idx;
    logic [BCNT_W-1:0]  bit_cnt_q;
    logic               phase_q;
    logic               active_q;
    logic               mark_q;
    logic               clk_en_q;
    logic               is_last;
    logic               is_first;
    logic               line_done;

    // Decode the synchronisation scheme
    always_comb mode = sync_mode_e'(sync_sel);

    // Index of the final line for the current frame length
    always_comb last_idx = op_ext ? IDX_W'(FRAME_MAX - 1) : IDX_W'(ARRAY_LINES - 1);

    // Classify the line about to be loaded
    always_comb begin
        is_last  = (next_idx_q >= last_idx);
        is_first = (next_idx_q == '0);
        use_pat  = xfer_test | (next_idx_q >= IDX_W'(ARRAY_LINES));
    end

    // A shift happens at the end of the second cycle of each bit
    always_comb shift_en = phase_q & ~row_load;

    // The final shift of a line
    always_comb line_done = shift_en & active_q & (bit_cnt_q == BCNT_W'(LANE_BITS - 1));

    // Bit phase: cleared by a load, toggles otherwise
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= 1'b0;
        end else if (row_load) begin
            phase_q <= 1'b0;
        end else begin
            phase_q <= ~phase_q;
        end
    end

    // Bit count and activity inside the current line
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_cnt_q <= '0;
            active_q  <= 1'b0;
        end else if (row_load) begin
            bit_cnt_q <= '0;
            active_q  <= 1'b1;
        end else if (shift_en && active_q) begin
            bit_cnt_q <= bit_cnt_q + 1'b1;
            if (line_done) begin
                active_q <= 1'b0;
            end
        end
    end

    // Line index, which wraps at the frame end
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            next_idx_q <= '0;
        end else if (row_load) begin
            next_idx_q <= is_last ? '0 : next_idx_q + 1'b1;
        end
    end

    // Marker: set for a requested last line, cleared when that line finishes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mark_q <= 1'b0;
        end else if (row_load) begin
            mark_q <= is_last & sync_req;
        end else if (line_done) begin
            mark_q <= 1'b0;
        end
    end

    // Clock gate for gated mode: changes only when a first line is loaded
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            clk_en_q <= 1'b0;
        end else if (row_load && is_first) begin
            clk_en_q <= sync_req;
        end
    end

    // Forwarded clock is high in the second half of every bit
    always_comb dclk_out = phase_q & ((mode == SYNC_MARKER) | clk_en_q);

    // Marker goes straight to the pad
    always_comb marker = mark_q;

endmodule

// File: rtl/disc_row_serializer.sv
// Module: top level of the discriminator row serializer.
// Splits a ROW_BITS row into LANES pads of ROW_BITS/LANES bits each.
// Assumes: ROW_BITS is a multiple of LANES; mask and pattern are static
// while a row is being loaded.
module disc_row_serializer
    import dser_pkg::*;
#(
    parameter int ROW_BITS    = DEF_ROW_BITS,
    parameter int LANES       = DEF_LANES,
    parameter int ARRAY_LINES = DEF_ARRAY_LINES,
    parameter int TEST_LINES  = DEF_TEST_LINES
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                row_load,
    input  logic [ROW_BITS-1:0] row_data,
    input  logic [ROW_BITS-1:0] disc_mask,
    input  logic [ROW_BITS-1:0] test_pattern,
    input  logic                op_ext,
    input  logic                xfer_test,
    input  logic                sync_sel,
    input  logic                sync_req,
    output logic [LANES-1:0]    sdata,
    output logic                marker,
    output logic                dclk_out
);

    localparam int LANE_BITS = ROW_BITS / LANES;

    logic                use_pat;
    logic                shift_en;
    logic [ROW_BITS-1:0] word;

    dser_frame_ctl #(
        .ARRAY_LINES (ARRAY_LINES),
        .TEST_LINES  (TEST_LINES),
        .LANE_BITS   (LANE_BITS)
    ) u_ctl (
        .clk       (clk),
        .rst_n     (rst_n),
        .row_load  (row_load),
        .op_ext    (op_ext),
        .xfer_test (xfer_test),
        .sync_sel  (sync_sel),
        .sync_req  (sync_req),
        .use_pat   (use_pat),
        .shift_en  (shift_en),
        .marker    (marker),
        .dclk_out  (dclk_out)
    );

    dser_word_sel #(
        .ROW_BITS (ROW_BITS)
    ) u_sel (
        .disc    (row_data),
        .mask    (disc_mask),
        .pattern (test_pattern),
        .use_pat (use_pat),
        .word    (word)
    );

    // One shift register per pad; lane k owns word slice k
    for (genvar k = 0; k < LANES; k++) begin : g_lane
        dser_lane #(
            .LANE_BITS (LANE_BITS)
        ) u_lane (
            .clk   (clk),
            .rst_n (rst_n),
            .load  (row_load),
            .shift (shift_en),
            .din   (word[k*LANE_BITS +: LANE_BITS]),
            .sout  (sdata[k])
        );
    end

endmodule

// File: rtl/dser_checker.sv
// Module: property checker for disc_row_serializer, attached by bind below.
// Assumes: it only observes ports of the top module.
module dser_checker #(
    parameter int ROW_BITS = 128,
    parameter int LANES    = 16
) (
    input logic                clk,
    input logic                rst_n,
    input logic                row_load,
    input logic [ROW_BITS-1:0] test_pattern,
    input logic                xfer_test,
    input logic                sync_sel,
    input logic                sync_req,
    input logic [LANES-1:0]    sdata,
    input logic                marker,
    input logic                dclk_out
);

    localparam int LANE_BITS = ROW_BITS / LANES;

    // Top bit of every lane slice of a word
    function automatic logic [LANES-1:0] lane_tops(input logic [ROW_BITS-1:0] w);
        logic [LANES-1:0] r;
        for (int k = 0; k < LANES; k++) begin
            r[k] = w[k*LANE_BITS + LANE_BITS - 1];
        end
        return r;
    endfunction

    // R8: the forwarded clock is never high for two cycles in a row
    a_r8_half_rate: assert property (@(posedge clk) disable iff (!rst_n)
        dclk_out |=> !dclk_out);

    // R2: in marker mode, data holds over a first-half cycle with no load
    a_r2_bit_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!sync_sel && !row_load && !dclk_out) |=> $stable(sdata));

    // R6: a transfer-test load puts the pattern's top lane bits on the pads
    a_r6_pattern_first: assert property (@(posedge clk) disable iff (!rst_n)
        (row_load && xfer_test) |=> (sdata == lane_tops($past(test_pattern))));

    // R7: the marker rises only right after a load
    a_r7_marker_after_load: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(marker) |-> $past(row_load));

    // R7: a load with no request clears the marker
    a_r7_no_request_no_marker: assert property (@(posedge clk) disable iff (!rst_n)
        (row_load && !sync_req) |=> !marker);

endmodule

bind disc_row_serializer dser_checker #(
    .ROW_BITS (ROW_BITS),
    .LANES    (LANES)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .row_load     (row_load),
    .test_pattern (test_pattern),
    .xfer_test    (xfer_test),
    .sync_sel     (sync_sel),
    .sync_req     (sync_req),
    .sdata        (sdata),
    .marker       (marker),
    .dclk_out     (dclk_out)
);

// File: tb/disc_row_serializer_tb.sv
// Directed bench for disc_row_serializer; one task per scenario.
module disc_row_serializer_tb;

    localparam int RB = 128;
    localparam int LN = 16;
    localparam int AL = 3;
    localparam int TL = 2;

    localparam logic [RB-1:0] D0 = {4{32'h8E3D_5A71}};
    localparam logic [RB-1:0] D1 = {4{32'h13F0_C6B9}};
    localparam logic [RB-1:0] D2 = {8{16'h7BE4}};
    localparam logic [RB-1:0] MK = {16{8'h81}};
    localparam logic [RB-1:0] PT = {4{32'hDEAD_F00D}};

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          row_load = 1'b0;
    logic [RB-1:0] row_data = '0;
    logic [RB-1:0] disc_mask = '0;
    logic [RB-1:0] test_pattern = '0;
    logic          op_ext = 1'b0;
    logic          xfer_test = 1'b0;
    logic          sync_sel = 1'b0;
    logic          sync_req = 1'b0;
    logic [LN-1:0] sdata;
    logic          marker;
    logic          dclk_out;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    disc_row_serializer #(
        .ROW_BITS    (RB),
        .LANES       (LN),
        .ARRAY_LINES (AL),
        .TEST_LINES  (TL)
    ) u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .row_load     (row_load),
        .row_data     (row_data),
        .disc_mask    (disc_mask),
        .test_pattern (test_pattern),
        .op_ext       (op_ext),
        .xfer_test    (xfer_test),
        .sync_sel     (sync_sel),
        .sync_req     (sync_req),
        .sdata        (sdata),
        .marker       (marker),
        .dclk_out     (dclk_out)
    );

    // Compare {sdata, marker, dclk_out} with the expected value
    task automatic check(input string req, input logic [LN+1:0] act, input logic [LN+1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    // Bit j of every lane, lane k taking word bit 8k+7-j
    function automatic logic [LN-1:0] lane_bits(input logic [RB-1:0] w, input int j);
        logic [LN-1:0] r;
        for (int k = 0; k < LN; k++) r[k] = w[k*8 + 7 - j];
        return r;
    endfunction

    // Reset, check the reset state (R1), release at a falling edge
    task automatic do_reset();
        rst_n = 1'b0; row_load = 1'b0;
        @(negedge clk); @(negedge clk);
        check("R1", {sdata, marker, dclk_out}, '0);
        rst_n = 1'b1;
    endtask

    // Load one row at this falling edge and check all 16 cycles of it
    task automatic run_line(input string req, input logic [RB-1:0] data,
                            input logic [RB-1:0] expw, input bit expm, input bit expclk);
        row_load = 1'b1; row_data = data;
        @(negedge clk);
        row_load = 1'b0;
        for (int c = 0; c < 16; c++) begin
            if (c > 0) @(negedge clk);
            check(req, {sdata, marker, dclk_out},
                  {lane_bits(expw, c / 2), expm, expclk && (c % 2 == 1)});
        end
    endtask

    // R1, R8, R10: free-running clock and zero data with no loads
    task automatic t_free_clock();
        logic prev;
        do_reset();
        prev = 1'b0;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            check("R8", {sdata, marker, dclk_out}, {{LN{1'b0}}, 1'b0, ~prev});
            prev = dclk_out;
        end
    endtask

    // R2, R7: plain lines, no request, no marker
    task automatic t_plain();
        do_reset(); op_ext = 0; xfer_test = 0; sync_sel = 0; sync_req = 0; disc_mask = '0;
        run_line("R2", D0, D0, 1'b0, 1'b1);
        run_line("R2", D1, D1, 1'b0, 1'b1);
        run_line("R7", D2, D2, 1'b0, 1'b1);
    endtask

    // R3: masked discriminators read as zero
    task automatic t_mask();
        do_reset(); disc_mask = MK;
        run_line("R3", D0, D0 & ~MK, 1'b0, 1'b1);
        run_line("R3", D1, D1 & ~MK, 1'b0, 1'b1);
        disc_mask = '0;
    endtask

    // R5, R7: 3-line frames, marker on each last line
    task automatic t_markers();
        do_reset(); sync_req = 1;
        for (int f = 0; f < 2; f++) begin
            run_line("R5", D0, D0, 1'b0, 1'b1);
            run_line("R5", D1, D1, 1'b0, 1'b1);
            run_line("R7", D2, D2, 1'b1, 1'b1);
        end
        sync_req = 0;
    endtask

    // R4, R5: appended pattern lines, unmasked, marker on the final one
    task automatic t_appended();
        do_reset(); op_ext = 1; sync_req = 1; disc_mask = MK; test_pattern = PT;
        run_line("R5", D0, D0 & ~MK, 1'b0, 1'b1);
        run_line("R5", D1, D1 & ~MK, 1'b0, 1'b1);
        run_line("R5", D2, D2 & ~MK, 1'b0, 1'b1);
        run_line("R4", D0, PT, 1'b0, 1'b1);
        run_line("R4", D1, PT, 1'b1, 1'b1);
        run_line("R5", D2, D2 & ~MK, 1'b0, 1'b1);
        op_ext = 0; sync_req = 0; disc_mask = '0;
    endtask

    // R6: transfer test sends the pattern, marker still on the last line
    task automatic t_xfer();
        do_reset(); xfer_test = 1; sync_req = 1; disc_mask = MK; test_pattern = PT;
        run_line("R6", D0, PT, 1'b0, 1'b1);
        run_line("R6", D1, PT, 1'b0, 1'b1);
        run_line("R6", D2, PT, 1'b1, 1'b1);
        run_line("R6", D0, PT, 1'b0, 1'b1);
        xfer_test = 0; sync_req = 0; disc_mask = '0;
    endtask

    // R10: data returns to zero and the marker drops after a line
    task automatic t_idle();
        do_reset(); sync_req = 1;
        run_line("R10", D0, D0, 1'b0, 1'b1);
        run_line("R10", D1, D1, 1'b0, 1'b1);
        run_line("R10", D2, D2, 1'b1, 1'b1);
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            check("R10", {sdata, marker}, '0);
        end
        sync_req = 0;
        @(negedge clk);
    endtask

    // R9: gated clock starts and stops only at first-line loads
    task automatic t_sync2();
        do_reset(); sync_sel = 1; sync_req = 0;
        run_line("R9", D0, D0, 1'b0, 1'b0);
        run_line("R9", D1, D1, 1'b0, 1'b0);
        sync_req = 1;
        run_line("R9", D2, D2, 1'b1, 1'b0);
        run_line("R9", D0, D0, 1'b0, 1'b1);
        run_line("R9", D1, D1, 1'b0, 1'b1);
        sync_req = 0;
        run_line("R9", D2, D2, 1'b0, 1'b1);
        run_line("R9", D0, D0, 1'b0, 1'b0);
        sync_sel = 0;
    endtask

    initial begin
        t_free_clock();
        t_plain();
        t_mask();
        t_markers();
        t_appended();
        t_xfer();
        t_idle();
        t_sync2();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    // Watchdog: a hung run counts as one failed check
    initial begin
        #(200000 * 8);
        if (!done) begin
            done = 1'b1;
            n_chk++; n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule